// File: doc/BRIEF.md
# USB Root Port Wake Event Controller

This block holds the status of a single USB host root port and updates it from line events reported by the PHY: attach, detach, over-current and a resume K-state arriving on a suspended port. It keeps the port flags (attached, enabled, suspended, forced resume, over-current active) and three sticky change bits, and it raises a port-change summary bit that can drive a level interrupt.

While the controller sits in a low-power state, an event can also raise a wake request toward the power manager. Each event class has its own wake-enable bit. A separate power-management status flag records every wake-capable event, whether or not a wake request was issued.

Software reaches the block through a one-cycle write strobe. Select 0 addresses the write-one-to-clear status bits. Select 1 addresses the control bits.

Top module: `usb_port_wake_ctl`

## Requirements
- R1: After reset every status flag, change bit, control bit, `irq` and `wake_req` are 0.
- R2: An `ev_attach` pulse while the port is not attached sets `attached`, `attach_chg`, `port_chg` and `pm_status` one cycle later.
- R3: An `ev_detach` pulse while the port is attached clears `attached`, `enabled`, `suspended` and `resume_drive`, and sets `attach_chg` and `port_chg`.
- R4: A rising edge of `oc_in` while attached sets `oc_active` and `oc_chg`, clears `enabled`, and sets `port_chg`. A later falling edge clears `oc_active` and sets `oc_chg` again. A rising edge while the port is not attached changes nothing.
- R5: A `ev_resume_k` pulse while suspended sets `resume_drive` and `port_chg`. On a port that is not suspended it has no effect.
- R6: A status write (`wr_sel`=0) clears `attach_chg` with bit 0, `oc_chg` with bit 1, `port_chg` with bit 2 and `pm_status` with bit 3. Zero bits leave a flag unchanged. A hardware set in the same cycle as a clear wins.
- R7: `irq` is high exactly while `port_chg` and the interrupt enable (control bit 3) are both 1.
- R8: `wake_req` is set by an attach, detach or over-current rise only while `low_power` is 1 and the matching wake enable is 1: control bit 4 for attach, bit 5 for detach, bit 6 for over-current. It clears one cycle after `low_power` falls.
- R9: `pm_status` is set on every attach, detach and over-current rise event, whatever the wake enables are.
- R10: A control write (`wr_sel`=1) sets `enabled` from bit 0 only if the port is attached. It sets `suspended` from bit 1 and `resume_drive` from bit 2 only if bit 0 is also written 1 on an attached port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_attach | input | 1 | Attach detected (one-cycle pulse) |
| ev_detach | input | 1 | Detach detected (one-cycle pulse) |
| ev_resume_k | input | 1 | Resume K-state received (one-cycle pulse) |
| oc_in | input | 1 | Live over-current level |
| low_power | input | 1 | Controller is not in its fully-on power state |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: status (write-one-to-clear), 1: control |
| wr_data | input | 8 | Write data |
| attached | output | 1 | Device attached |
| enabled | output | 1 | Port enabled |
| suspended | output | 1 | Port suspended |
| resume_drive | output | 1 | Forced resume, driven downstream |
| oc_active | output | 1 | Over-current present |
| attach_chg | output | 1 | Attach status changed |
| oc_chg | output | 1 | Over-current status changed |
| port_chg | output | 1 | Port change summary |
| pm_status | output | 1 | Wake-capable event seen |
| irq | output | 1 | Level interrupt |
| wake_req | output | 1 | Wake request to the power manager |

## Verification
The hardest cases to reach are a status clear landing in the same cycle as a hardware set, and a resume arriving on a suspended port. The bench reaches the first by issuing a detach pulse and a clear write in one cycle. It reaches the second by first attaching the port, then enabling and suspending it through a single control write. Wake behaviour is checked with the matching enable both on and off under `low_power`, so status updates and the wake line can be told apart.

// File: rtl/usb_port_wake_ctl.sv
module usb_port_wake_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_attach,
  input  logic       ev_detach,
  input  logic       ev_resume_k,
  input  logic       oc_in,
  input  logic       low_power,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  output logic       attached,
  output logic       enabled,
  output logic       suspended,
  output logic       resume_drive,
  output logic       oc_active,
  output logic       attach_chg,
  output logic       oc_chg,
  output logic       port_chg,
  output logic       pm_status,
  output logic       irq,
  output logic       wake_req
);

  logic oc_q, int_en, wk_att, wk_det, wk_oc;

  wire do_att   = ev_attach & ~attached;
  wire do_det   = ev_detach & attached;
  wire oc_rise  = oc_in & ~oc_q & attached;
  wire oc_fall  = ~oc_in & oc_active;
  wire do_res   = ev_resume_k & suspended & ~do_det;
  wire st_wr    = wr_en & ~wr_sel;
  wire ct_wr    = wr_en & wr_sel;
  wire ct_ok    = wr_data[0] & attached;
  wire wake_ev  = (do_att & wk_att) | (do_det & wk_det) | (oc_rise & wk_oc);

  assign irq = port_chg & int_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_q <= 1'b0; int_en <= 1'b0; wk_att <= 1'b0; wk_det <= 1'b0; wk_oc <= 1'b0;
      attached <= 1'b0; enabled <= 1'b0; suspended <= 1'b0; resume_drive <= 1'b0;
      oc_active <= 1'b0; attach_chg <= 1'b0; oc_chg <= 1'b0; port_chg <= 1'b0;
      pm_status <= 1'b0; wake_req <= 1'b0;
    end else begin
      oc_q <= oc_in;
      if (ct_wr) begin
        int_en <= wr_data[3];
        wk_att <= wr_data[4];
        wk_det <= wr_data[5];
        wk_oc  <= wr_data[6];
      end

      if (do_att)      attached <= 1'b1;
      else if (do_det) attached <= 1'b0;

      if (do_det | oc_rise) enabled <= 1'b0;
      else if (ct_wr)       enabled <= ct_ok;

      if (do_det | oc_rise) suspended <= 1'b0;
      else if (ct_wr)       suspended <= wr_data[1] & ct_ok;

      if (do_det)      resume_drive <= 1'b0;
      else if (do_res) resume_drive <= 1'b1;
      else if (ct_wr)  resume_drive <= wr_data[2] & ct_ok;

      if (oc_rise)      oc_active <= 1'b1;
      else if (!oc_in)  oc_active <= 1'b0;

      if (oc_rise | oc_fall)         oc_chg <= 1'b1;
      else if (st_wr & wr_data[1])   oc_chg <= 1'b0;

      if (do_att | do_det)           attach_chg <= 1'b1;
      else if (st_wr & wr_data[0])   attach_chg <= 1'b0;

      if (do_att | do_det | oc_rise | oc_fall | do_res) port_chg <= 1'b1;
      else if (st_wr & wr_data[2])                      port_chg <= 1'b0;

      if (do_att | do_det | oc_rise) pm_status <= 1'b1;
      else if (st_wr & wr_data[3])   pm_status <= 1'b0;

      if (!low_power)   wake_req <= 1'b0;
      else if (wake_ev) wake_req <= 1'b1;
    end
  end

  a_r2_attach_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_attach && !attached) |=> (attached && attach_chg && port_chg && pm_status));
  a_r3_detach_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_detach && attached) |=> (!attached && !enabled && !suspended && attach_chg && port_chg));
  a_r4_oc_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_in && !oc_q && attached) |=> (oc_active && oc_chg && !enabled));
  a_r5_resume_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_resume_k && suspended && !ev_detach) |=> (resume_drive && port_chg));
  a_r7_irq_needs_chg: assert property (@(posedge clk) disable iff (!rst_n)
    !port_chg |-> !irq);
  a_r8_wake_in_low_power: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && !$past(wake_req)) |-> $past(low_power));
  a_r10_enable_needs_attach: assert property (@(posedge clk) disable iff (!rst_n)
    enabled |-> attached);

endmodule

// File: tb/usb_port_wake_ctl_tb.sv
module usb_port_wake_ctl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_attach = 0, ev_detach = 0, ev_resume_k = 0, oc_in = 0, low_power = 0;
  logic wr_en = 0, wr_sel = 0;
  logic [7:0] wr_data = 8'h00;
  logic attached, enabled, suspended, resume_drive, oc_active;
  logic attach_chg, oc_chg, port_chg, pm_status, irq, wake_req;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  usb_port_wake_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .ev_attach(ev_attach), .ev_detach(ev_detach),
    .ev_resume_k(ev_resume_k), .oc_in(oc_in), .low_power(low_power),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .attached(attached), .enabled(enabled), .suspended(suspended),
    .resume_drive(resume_drive), .oc_active(oc_active), .attach_chg(attach_chg),
    .oc_chg(oc_chg), .port_chg(port_chg), .pm_status(pm_status), .irq(irq),
    .wake_req(wake_req));

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    step();
    wr_en = 0; wr_data = 8'h00;
  endtask

  task automatic t_reset();
    chk("R1", "attached", attached, 0);
    chk("R1", "port_chg", port_chg, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "wake_req", wake_req, 0);
    chk("R1", "pm_status", pm_status, 0);
  endtask

  task automatic t_attach();
    ev_attach = 1; step(); ev_attach = 0;
    chk("R2", "attached", attached, 1);
    chk("R2", "attach_chg", attach_chg, 1);
    chk("R2", "port_chg", port_chg, 1);
    chk("R9", "pm_status", pm_status, 1);
    chk("R8", "wake_req full power", wake_req, 0);
    chk("R7", "irq disabled", irq, 0);
  endtask

  task automatic t_w1c();
    wr(0, 8'h00);
    chk("R6", "zero write keeps attach_chg", attach_chg, 1);
    wr(0, 8'h05);
    chk("R6", "attach_chg cleared", attach_chg, 0);
    chk("R6", "port_chg cleared", port_chg, 0);
    wr(0, 8'h08);
    chk("R6", "pm_status cleared", pm_status, 0);
  endtask

  task automatic t_resume();
    wr(1, 8'h03);
    chk("R10", "enabled", enabled, 1);
    chk("R10", "suspended", suspended, 1);
    ev_resume_k = 1; step(); ev_resume_k = 0;
    chk("R5", "resume_drive", resume_drive, 1);
    chk("R5", "port_chg", port_chg, 1);
    chk("R7", "irq without enable", irq, 0);
    wr(1, 8'h0B);
    chk("R7", "irq with enable", irq, 1);
    wr(0, 8'h04);
    chk("R7", "irq after clear", irq, 0);
  endtask

  task automatic t_resume_disabled();
    wr(1, 8'h08);
    chk("R10", "enabled off", enabled, 0);
    ev_resume_k = 1; step(); ev_resume_k = 0;
    chk("R5", "no resume on disabled port", resume_drive, 0);
    chk("R5", "no port_chg on disabled port", port_chg, 0);
  endtask

  task automatic t_oc();
    wr(1, 8'h09);
    oc_in = 1; step(); step();
    chk("R4", "oc_active", oc_active, 1);
    chk("R4", "oc_chg", oc_chg, 1);
    chk("R4", "enabled dropped", enabled, 0);
    chk("R4", "port_chg", port_chg, 1);
    wr(0, 8'h06);
    oc_in = 0; step();
    chk("R4", "oc_active dropped", oc_active, 0);
    chk("R4", "oc_chg on fall", oc_chg, 1);
    wr(0, 8'h0E);
  endtask

  task automatic t_wake_detach();
    low_power = 1;
    wr(1, 8'h28);
    ev_detach = 1; step(); ev_detach = 0;
    chk("R3", "attached cleared", attached, 0);
    chk("R3", "attach_chg", attach_chg, 1);
    chk("R8", "wake_req raised", wake_req, 1);
    chk("R9", "pm_status", pm_status, 1);
    chk("R7", "irq", irq, 1);
    low_power = 0; step();
    chk("R8", "wake_req dropped", wake_req, 0);
    wr(0, 8'h0F);
  endtask

  task automatic t_enable_unattached();
    wr(1, 8'h03);
    chk("R10", "enable refused", enabled, 0);
    chk("R10", "suspend refused", suspended, 0);
  endtask

  task automatic t_wake_off();
    low_power = 1;
    wr(1, 8'h28);
    ev_attach = 1; step(); ev_attach = 0;
    chk("R8", "no wake with attach enable off", wake_req, 0);
    chk("R9", "pm_status still set", pm_status, 1);
    chk("R2", "attach_chg", attach_chg, 1);
    low_power = 0;
    wr(0, 8'h0F);
  endtask

  task automatic t_set_wins();
    ev_detach = 1; wr_en = 1; wr_sel = 0; wr_data = 8'h05;
    step();
    ev_detach = 0; wr_en = 0; wr_data = 8'h00;
    chk("R6", "set beats clear attach_chg", attach_chg, 1);
    chk("R6", "set beats clear port_chg", port_chg, 1);
    wr(0, 8'h0F);
  endtask

  task automatic t_oc_unattached();
    oc_in = 1; step(); step();
    chk("R4", "oc ignored when detached", oc_active, 0);
    chk("R4", "oc_chg untouched", oc_chg, 0);
    oc_in = 0; step();
  endtask

  initial begin
    repeat (3) step();
    t_reset();
    rst_n = 1; step();
    t_reset();
    t_attach();
    t_w1c();
    t_resume();
    t_resume_disabled();
    t_oc();
    t_wake_detach();
    t_enable_unattached();
    t_wake_off();
    t_set_wins();
    t_oc_unattached();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule